// File: doc/BRIEF.md
# I/O Virtual Address Translator

This unit turns a device-side virtual address into a 31-bit physical address. It takes one request at a time, with a read/write flag. From the page-table base and the window-start mask supplied by the register bank, it computes where the page-table entry lives. It reads that 32-bit entry through a valid/ready memory port and checks the entry's permission bits. It then either reports the physical address or records a fault.

The sequence is IDLE → FETCH → CHECK → DONE or FAULT → IDLE.
- **IDLE:** the unit accepts a request and captures the address, the direction and the computed entry address.
- **FETCH:** it issues one memory read and waits for the word to come back.
- **CHECK:** it evaluates the entry.
- **DONE:** pulses `done` with the physical address.
- **FAULT:** pulses `fault` and updates the status and fault-address registers.

Both DONE and FAULT return to IDLE on the next cycle. The entry word is used exactly as the memory port delivers it. No enable or bypass decision is made here; every accepted request is translated.

Top module: `iova_xlate`

## Requirements
- R1: After reset, `req_ready` is 1; `done`, `fault` and `mem_req_valid` are 0; `fault_status` and `fault_addr` are 0.
- R2: The memory read address is (`pt_base` << 4) + (((vaddr & ~`win_start`) >> 10) with bits 1:0 cleared), computed modulo 2^32. `pt_base` and `win_start` are sampled when the request is accepted.
- R3: Each translation issues exactly one memory request. `mem_req_valid` with a stable address is held until `mem_req_ready`, then drops. A response is taken only in a cycle after the request handshake.
- R4: On success, `pa` = {entry[26:8], vaddr[11:0]}. The cacheable bit (entry bit 7) and every other entry bit outside 26:8, 2 and 1 have no effect.
- R5: An entry with bit 1 (valid) clear produces a fault, for reads and writes alike.
- R6: A write whose entry has bit 2 (writable) clear faults. A read of a valid entry succeeds whatever bit 2 holds.
- R7: On a fault, `fault_status` becomes 0xC0820000 for a write and 0xC0860000 for a read. These are bits 31, 30 and 17 set, the value 8 in bits 23:20, and bit 18 set for a read.
- R8: On a fault, `fault_addr` becomes the request's virtual address with bits 11:0 cleared. Both fault registers keep their value across later successful translations.
- R9: `done` and `fault` are one-cycle pulses and never high together, and the unit is back in IDLE the cycle after either. `req_ready` is high only in IDLE, and `req_valid` with any address while busy has no effect on the translation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| pt_base | input | 32 | Page-table base register value |
| win_start | input | 32 | Window-start mask (bits cleared from vaddr) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry word returned |
| mem_rsp_data | input | 32 | Entry word |
| done | output | 1 | Successful translation pulse |
| pa | output | 31 | Physical address, valid with `done` |
| fault | output | 1 | Fault pulse |
| fault_status | output | 32 | Last fault status word |
| fault_addr | output | 32 | Page-aligned address of the last fault |

## Verification
The bench uses the full range of window masks and high base values so that the entry address wraps. A design that shifted before masking, or kept the low index bits, would read the wrong entry. Read accesses to non-writable entries must succeed while writes to them fault; a unit that checked the writable bit regardless of direction would fault on reads. The bench also toggles the cacheable and unused entry bits, which must not leak into `pa`. It holds `mem_req_ready` low for random stretches to catch a request that drops early or is issued twice. It drives a different request while the unit is busy; a unit that resampled then would translate the wrong address. After successful translations it confirms that the fault registers keep their last value.

// File: rtl/iova_pkg.sv
package iova_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_DONE,
        ST_FAULT
    } xl_state_e;

    localparam int PTE_VALID_BIT = 1;
    localparam int PTE_WRITE_BIT = 2;
    localparam int PPN_LSB       = 8;
    localparam int PPN_MSB       = 26;
    localparam int BASE_SHIFT    = 4;
    localparam int FST_RD_BIT    = 18;
    localparam logic [31:0] FST_FIXED = 32'hC082_0000;
endpackage

// File: rtl/iova_entry_addr.sv
module iova_entry_addr #(
    parameter int AW         = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] win,
    input  logic [AW-1:0] vaddr,
    output logic [AW-1:0] entry_addr
);
    import iova_pkg::*;
    localparam int IDX_SHIFT = PAGE_SHIFT - 2;

    logic [AW-1:0] masked;
    logic [AW-1:0] scaled;

    always_comb begin
        masked     = vaddr & ~win;
        scaled     = (masked >> IDX_SHIFT) & ~AW'(3);
        entry_addr = (base << BASE_SHIFT) + scaled;
    end
endmodule

// File: rtl/iova_pte_check.sv
module iova_pte_check #(
    parameter int PAGE_SHIFT = 12,
    localparam int PA_W = iova_pkg::PPN_MSB - iova_pkg::PPN_LSB + 1 + PAGE_SHIFT
) (
    input  logic [31:0]           pte,
    input  logic                  is_write,
    input  logic [PAGE_SHIFT-1:0] offset,
    output logic                  ok,
    output logic [PA_W-1:0]       pa
);
    import iova_pkg::*;

    always_comb begin
        ok = pte[PTE_VALID_BIT] && (!is_write || pte[PTE_WRITE_BIT]);
        pa = {pte[PPN_MSB:PPN_LSB], offset};
    end
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate #(
    parameter int AW         = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int PA_W = iova_pkg::PPN_MSB - iova_pkg::PPN_LSB + 1 + PAGE_SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_vaddr,
    input  logic            req_write,
    input  logic [AW-1:0]   pt_base,
    input  logic [AW-1:0]   win_start,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [31:0]     mem_rsp_data,
    output logic            done,
    output logic [PA_W-1:0] pa,
    output logic            fault,
    output logic [31:0]     fault_status,
    output logic [AW-1:0]   fault_addr
);
    import iova_pkg::*;

    xl_state_e state_q, state_d;

    logic [AW-1:0]   vaddr_q;
    logic            write_q;
    logic [AW-1:0]   eaddr_q;
    logic            sent_q;
    logic [31:0]     pte_q;
    logic [PA_W-1:0] pa_q;
    logic [31:0]     fstat_q;
    logic [AW-1:0]   faddr_q;

    logic [AW-1:0]   eaddr_c;
    logic            pte_ok;
    logic [PA_W-1:0] pa_c;

    iova_entry_addr #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_eaddr (
        .base       (pt_base),
        .win        (win_start),
        .vaddr      (req_vaddr),
        .entry_addr (eaddr_c)
    );

    iova_pte_check #(.PAGE_SHIFT(PAGE_SHIFT)) u_check (
        .pte      (pte_q),
        .is_write (write_q),
        .offset   (vaddr_q[PAGE_SHIFT-1:0]),
        .ok       (pte_ok),
        .pa       (pa_c)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_FETCH;
            ST_FETCH: if (sent_q && mem_rsp_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = pte_ok ? ST_DONE : ST_FAULT;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            write_q <= 1'b0;
            eaddr_q <= '0;
            sent_q  <= 1'b0;
            pte_q   <= '0;
            pa_q    <= '0;
            fstat_q <= '0;
            faddr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sent_q <= 1'b0;
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        write_q <= req_write;
                        eaddr_q <= eaddr_c;
                    end
                end
                ST_FETCH: begin
                    if (!sent_q && mem_req_ready) sent_q <= 1'b1;
                    if (sent_q && mem_rsp_valid) pte_q <= mem_rsp_data;
                end
                ST_CHECK: begin
                    if (pte_ok) begin
                        pa_q <= pa_c;
                    end else begin
                        fstat_q <= FST_FIXED | (32'(!write_q) << FST_RD_BIT);
                        faddr_q <= {vaddr_q[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                    end
                end
                ST_DONE, ST_FAULT: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_FETCH) && !sent_q;
        mem_req_addr  = eaddr_q;
        done          = (state_q == ST_DONE);
        fault         = (state_q == ST_FAULT);
        pa            = pa_q;
        fault_status  = fstat_q;
        fault_addr    = faddr_q;
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> (req_ready && !done && !fault)); // R9
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R3
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_status[31:30] == 2'b11 && fault_status[23:20] == 4'h8
                   && fault_status[17] && fault_addr[PAGE_SHIFT-1:0] == '0)); // R7
    AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $stable(fault_status)); // R8
endmodule

// File: tb/iova_xlate_test.sv
module iova_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic        req_ready;
    logic [31:0] req_vaddr, pt_base, win_start;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done, fault;
    logic [30:0] pa;
    logic [31:0] fault_status, fault_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_fst = 32'h0;
    logic [31:0] last_fad = 32'h0;

    always #4 clk = ~clk;

    iova_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .pt_base(pt_base),
        .win_start(win_start), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .pa(pa), .fault(fault), .fault_status(fault_status),
        .fault_addr(fault_addr)
    );

    function automatic logic [31:0] exp_eaddr(input logic [31:0] b, w, v);
        return (b << 4) + (((v & ~w) >> 10) & 32'hFFFF_FFFC);
    endfunction

    function automatic logic [30:0] exp_pa(input logic [31:0] e, v);
        return {e[26:8], v[11:0]};
    endfunction

    function automatic bit exp_ok(input logic [31:0] e, input logic wr);
        return e[1] && (!wr || e[2]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic xlate(input logic [31:0] v, input logic wr, input logic [31:0] b,
                         input logic [31:0] w, input logic [31:0] e, input bit busy_noise);
        logic [31:0] ea;
        int guard;
        ea = exp_eaddr(b, w, v);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v; req_write = wr; pt_base = b; win_start = w;
        @(negedge clk);
        if (busy_noise) begin
            req_vaddr = $urandom; req_write = $urandom; pt_base = $urandom; win_start = $urandom;
        end else begin
            req_valid = 1'b0;
        end
        check(!req_ready, "R9 busy", 32'(req_ready), 32'h0);
        guard = 0;
        while (!mem_req_valid && guard < 20) begin @(negedge clk); guard++; end
        check(mem_req_valid, "R3 request", 32'(mem_req_valid), 32'h1);
        check(mem_req_addr == ea, "R2 entry addr", mem_req_addr, ea);
        for (int d = $urandom_range(0, 3); d > 0; d--) begin
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == ea, "R3 hold", mem_req_addr, ea);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = $urandom;
        check(!mem_req_valid, "R3 single", 32'(mem_req_valid), 32'h0);
        for (int d = $urandom_range(0, 3); d > 0; d--) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = e;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom; mem_req_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_ok(e, wr)) begin
            check(done && !fault, "R5/R6 success", {30'h0, done, fault}, 32'h2);
            check(pa == exp_pa(e, v), "R4 pa", {1'b0, pa}, {1'b0, exp_pa(e, v)});
            check(fault_status == last_fst && fault_addr == last_fad, "R8 keep",
                  fault_status, last_fst);
        end else begin
            last_fst = wr ? 32'hC082_0000 : 32'hC086_0000;
            last_fad = {v[31:12], 12'h000};
            check(fault && !done, "R5/R6 fault", {30'h0, done, fault}, 32'h1);
            check(fault_status == last_fst, "R7 status", fault_status, last_fst);
            check(fault_addr == last_fad, "R8 fault addr", fault_addr, last_fad);
        end
        @(negedge clk);
        check(!done && !fault && req_ready, "R9 pulse",
              {29'h0, done, fault, req_ready}, 32'h1);
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        pt_base = '0; win_start = '0; mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        check(req_ready && !done && !fault && !mem_req_valid, "R1 control",
              {28'h0, req_ready, done, fault, mem_req_valid}, 32'h8);
        check(fault_status == 0 && fault_addr == 0, "R1 fault regs", fault_status, 32'h0);
        rst_n = 1'b1;

        // Directed corners
        xlate(32'hFF12_3ABC, 1'b0, 32'h0010_0000, 32'hFF00_0000, 32'h0123_4586, 1'b0); // R4 cacheable ignored
        xlate(32'hFFFF_FFFF, 1'b1, 32'h07FF_FC00, 32'h8000_0000, 32'h07FF_FF06, 1'b0); // R2 large index
        xlate(32'hF000_1234, 1'b1, 32'h0020_0000, 32'hF000_0000, 32'h0000_1202, 1'b0); // R6 write no perm
        xlate(32'hF000_5678, 1'b0, 32'h0020_0000, 32'hF000_0000, 32'h0000_1202, 1'b0); // R6 read ok
        xlate(32'hC001_0FFF, 1'b0, 32'h0000_0400, 32'hC000_0000, 32'hF800_00FD, 1'b0); // R5 invalid read
        xlate(32'hC002_0000, 1'b1, 32'h0000_0400, 32'hC000_0000, 32'h0000_0004, 1'b0); // R5 invalid write
        xlate(32'h8765_4321, 1'b0, 32'hF000_0000, 32'h0000_0000, 32'h0555_5502, 1'b1); // R9 busy noise, R2 wrap
        xlate(32'h1234_5678, 1'b1, 32'h0000_1000, 32'hFE00_0000, 32'hF8AA_AA86, 1'b1); // R9

        // Random mix
        for (int i = 0; i < 200; i++) begin
            logic [31:0] e;
            e = $urandom;
            e[1] = ($urandom_range(0, 3) != 0);
            xlate($urandom, 1'($urandom), $urandom, 32'hFFFF_FFFF << (24 + $urandom_range(0, 7)),
                  e, ($urandom_range(0, 3) == 0));
        end
        finish_run();
    end
endmodule